// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial Word EEPROM Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host drives chip select, a serial clock and a data line into it, and it returns data on a single output line. Every rising edge of the serial clock moves one bit. A command opens with a 1 that marks its start. A two-bit opcode follows, then an address sent MSB first, and for the two write forms a 16-bit data word. The block reads a word, writes a word, erases a word, erases or writes the whole array, and switches programming on or off through a write-enable latch.

The serial inputs are expected to be synchronous to the system clock `clk`. The block detects serial-clock rising edges by comparing the input with its value one `clk` cycle earlier. Storage is a register array that reset fills with all ones. The parameter `ADDR_W` selects a 6-bit address (64 words) or an 8-bit address (256 words).

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, every word reads 16'hFFFF, and `dout` is 0.
- R2: The decoder ignores 0 bits until a 1 start bit arrives with `cs` high. It then takes two opcode bits and then ADDR_W address bits, MSB first.
- R3: Opcode 2'b10 (read): on the serial-clock rise that carries the last address bit, `dout` becomes a dummy 0. Each of the next 16 rises then presents one bit of the addressed word, bit 15 first.
- R4: Opcode 2'b01 (write) takes 16 data bits, bit 15 first. On the 16th data rise it stores them in the addressed word if programming is enabled.
- R5: Opcode 2'b11 (erase) sets the addressed word to 16'hFFFF if programming is enabled.
- R6: With opcode 2'b00, the top two address bits 2'b11 set the write-enable latch and 2'b00 clear it. The lower address bits have no effect.
- R7: Opcode 2'b00 with top address bits 2'b10 (erase all) sets every word to 16'hFFFF if programming is enabled.
- R8: Opcode 2'b00 with top address bits 2'b01 (write all) takes 16 data bits and stores them in every word if programming is enabled.
- R9: While the write-enable latch is clear, write, erase, erase-all and write-all leave the memory unchanged.
- R10: Dropping `cs` at any point abandons a partial command, returns the decoder to waiting for a start bit, and drives `dout` to 0 from the next `clk` cycle on.
- R11: `dout` is 0 at every point except between the dummy bit and the end of a read's 16 data bits. After a read has sent bit 0, the next serial-clock rise drives `dout` back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; rising edges move bits |
| di | input | 1 | Serial command, address and data input |
| dout | output | 1 | Serial read data output |

## Verification
The assertions assume that `cs`, `sck` and `di` change only between `clk` edges and that each level of `sck` lasts at least one `clk` cycle, so that every rising edge is seen exactly once. They also assume that reset is held low at time zero. The bench changes inputs only on falling `clk` edges, holds each `sck` phase for two `clk` cycles and raises `cs` only while `sck` is low, so no false edge appears when a command opens.

// File: rtl/mw_pkg.sv
// Package mw_pkg
// Shared opcode codes and decoder states for the serial EEPROM model.
// Assumes nothing beyond a 2-bit opcode field and 2-bit control-select field.
package mw_pkg;

    localparam logic [1:0] OPC_CTRL  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] CTL_LOCK   = 2'b00;
    localparam logic [1:0] CTL_FILL   = 2'b01;
    localparam logic [1:0] CTL_WIPE   = 2'b10;
    localparam logic [1:0] CTL_UNLOCK = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OPC  = 3'd1,
        ST_ADR  = 3'd2,
        ST_DAT  = 3'd3,
        ST_RD   = 3'd4,
        ST_END  = 3'd5
    } dec_state_t;

endpackage

// File: rtl/mw_edge.sv
// Module mw_edge
// Detects rising edges of the serial clock in the system clock domain.
// Assumes sck is already synchronous to clk and each level lasts >= 1 cycle.
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);

    logic sck_q;

    // Remember the serial clock level from the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck;
        end
    end

    // A rise is a high level now that was low one cycle ago.
    always_comb begin
        rise = sck & ~sck_q;
    end

endmodule

// File: rtl/mw_wel.sv
// Module mw_wel
// Write-enable latch gating every programming command.
// Assumes set and clear are never requested in the same cycle.
module mw_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic wen
);

    // Hold programming permission; reset leaves programming locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen <= 1'b0;
        end else if (set_en) begin
            wen <= 1'b1;
        end else if (clr_en) begin
            wen <= 1'b0;
        end
    end

endmodule

// File: rtl/mw_array.sv
// Module mw_array
// Word storage with one single-word write port, an all-words write port and
// one combinational read port. Reset fills every word with ones (erased).
// Assumes at most one of we_one/we_all is asserted in a cycle.
module mw_array #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Update stored words: reset erases all, then single or broadcast writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= '1;
            end else if (we_all || (we_one && (addr == ADDR_W'(i)))) begin
                mem[i] <= wdata;
            end
        end
    end

    // Return the addressed word without delay.
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/mw_decode.sv
// Module mw_decode
// Serial command decoder: start bit, opcode, address and data capture,
// read-data shifting, and generation of write and latch requests.
// Assumes rise marks one system cycle per serial-clock rising edge and that
// ADDR_W is at least 2 and no larger than WORD_W.
module mw_decode
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              di,
    input  logic              rise,
    input  logic              wen,
    input  logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] maddr,
    output logic [WORD_W-1:0] wdata,
    output logic              we_one,
    output logic              we_all,
    output logic              lock_set,
    output logic              lock_clr,
    output logic              dout
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(1);

    dec_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] adr;
    logic [WORD_W-1:0] dat;
    logic [WORD_W-1:0] rsh;
    logic              dout_q;

    logic              step;
    logic [ADDR_W-1:0] adr_n;
    logic [WORD_W-1:0] dat_n;
    logic [1:0]        ctl_n;
    logic              adr_done;
    logic              dat_done;

    // Next-bit views of the shift registers and end-of-field strobes.
    always_comb begin
        step     = rise & cs;
        adr_n    = {adr[ADDR_W-2:0], di};
        dat_n    = {dat[WORD_W-2:0], di};
        ctl_n    = adr_n[ADDR_W-1:ADDR_W-2];
        adr_done = step && (st == ST_ADR) && (cnt == ADR_LAST);
        dat_done = step && (st == ST_DAT) && (cnt == DAT_LAST);
    end

    // Pick the array address: held address during data, incoming otherwise.
    always_comb begin
        maddr = (st == ST_DAT) ? adr : adr_n;
    end

    // Build array write requests, gated by the write-enable latch.
    always_comb begin
        we_one = 1'b0;
        we_all = 1'b0;
        wdata  = '1;
        if (dat_done) begin
            wdata = dat_n;
            we_one = wen && (opc == OPC_WRITE);
            we_all = wen && (opc == OPC_CTRL);
        end else if (adr_done) begin
            we_one = wen && (opc == OPC_ERASE);
            we_all = wen && (opc == OPC_CTRL) && (ctl_n == CTL_WIPE);
        end
    end

    // Requests to open or close programming from control commands.
    always_comb begin
        lock_set = adr_done && (opc == OPC_CTRL) && (ctl_n == CTL_UNLOCK);
        lock_clr = adr_done && (opc == OPC_CTRL) && (ctl_n == CTL_LOCK);
    end

    // Command sequencer: advances one field bit per serial-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            opc    <= '0;
            adr    <= '0;
            dat    <= '0;
            rsh    <= '0;
            dout_q <= 1'b0;
        end else if (!cs) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            dout_q <= 1'b0;
        end else if (rise) begin
            case (st)
                ST_IDLE: begin
                    if (di) begin
                        st  <= ST_OPC;
                        cnt <= '0;
                    end
                end
                ST_OPC: begin
                    opc <= {opc[0], di};
                    if (cnt == OPC_LAST) begin
                        st  <= ST_ADR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADR: begin
                    adr <= adr_n;
                    if (cnt == ADR_LAST) begin
                        cnt <= '0;
                        case (opc)
                            OPC_READ: begin
                                rsh    <= rdata;
                                dout_q <= 1'b0;
                                st     <= ST_RD;
                            end
                            OPC_WRITE: st <= ST_DAT;
                            OPC_ERASE: st <= ST_END;
                            default: begin
                                st <= (ctl_n == CTL_FILL) ? ST_DAT : ST_END;
                            end
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DAT: begin
                    dat <= dat_n;
                    if (cnt == DAT_LAST) begin
                        st  <= ST_END;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD: begin
                    dout_q <= rsh[WORD_W-1];
                    rsh    <= {rsh[WORD_W-2:0], 1'b0};
                    if (cnt == DAT_LAST) begin
                        st  <= ST_END;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    dout_q <= 1'b0;
                end
            endcase
        end
    end

    // Drive the serial output from its register.
    always_comb begin
        dout = dout_q;
    end

endmodule

// File: rtl/mw_eeprom.sv
// Module mw_eeprom
// Top of the serial word EEPROM model: edge detection, decoder, write-enable
// latch and storage array. Assumes cs, sck and di are synchronous to clk.
module mw_eeprom #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic di,
    output logic dout
);

    logic              sck_rise;
    logic              wen_q;
    logic              we_one;
    logic              we_all;
    logic              lock_set;
    logic              lock_clr;
    logic [ADDR_W-1:0] maddr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;

    mw_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (sck_rise)
    );

    mw_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (lock_set),
        .clr_en (lock_clr),
        .wen    (wen_q)
    );

    mw_array #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_one (we_one),
        .we_all (we_all),
        .addr   (maddr),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    mw_decode #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .di       (di),
        .rise     (sck_rise),
        .wen      (wen_q),
        .rdata    (rdata),
        .maddr    (maddr),
        .wdata    (wdata),
        .we_one   (we_one),
        .we_all   (we_all),
        .lock_set (lock_set),
        .lock_clr (lock_clr),
        .dout     (dout)
    );

endmodule

// File: rtl/mw_eeprom_chk.sv
// Module mw_eeprom_chk
// Temporal checks on the EEPROM model, bound into every mw_eeprom instance.
// Assumes reset is asserted from time zero.
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic sck_rise,
    input logic wen,
    input logic we_one,
    input logic we_all
);

    // R10: with select low the output is quiet on the following cycle.
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout);

    // R3: output moves only after a serial-clock rise or a deselect.
    a_r3_dout_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sck_rise) || !$past(cs)));

    // R6: the write-enable latch changes only on a serial-clock rise.
    a_r6_latch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen) |-> $past(sck_rise));

    // R9: no array write reaches storage while programming is locked.
    a_r9_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |-> wen);

    // R7: single-word and broadcast writes never coincide.
    a_r7_single_or_all: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_one, we_all}));

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .dout     (dout),
    .sck_rise (sck_rise),
    .wen      (wen_q),
    .we_one   (we_one),
    .we_all   (we_all)
);

// File: tb/sim_mw_eeprom.sv
// Directed bench for mw_eeprom with 6-bit addresses and 16-bit words.
module sim_mw_eeprom;

    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sck = 1'b0;
    logic di = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .WORD_W(16)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .sck   (sck),
        .di    (di),
        .dout  (dout)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk);
        di = b;
        sck = 1'b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sel_on();
        @(negedge clk);
        sck = 1'b0;
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk);
        cs = 1'b0;
        sck = 1'b0;
        di = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic header(input logic [1:0] op, input logic [AW-1:0] a);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) pulse(d[i]);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        sel_on();
        header(op, a);
        sel_off();
    endtask

    task automatic cmd_data(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
        sel_on();
        header(op, a);
        send_word(d);
        chk("R11 dout low after write", {15'd0, dout}, 16'd0);
        sel_off();
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [15:0] v);
        sel_on();
        header(2'b10, a);
        chk("R3 dummy bit", {15'd0, dout}, 16'd0);
        v = '0;
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            v[i] = dout;
        end
        pulse(1'b0);
        chk("R11 dout low after read", {15'd0, dout}, 16'd0);
        sel_off();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 dout at reset", {15'd0, dout}, 16'd0);
        read_word(6'd5, v);
        chk("R1 erased at reset", v, 16'hFFFF);
    endtask

    task automatic t_locked();
        logic [15:0] v;
        cmd_data(2'b01, 6'd3, 16'h1234);
        read_word(6'd3, v);
        chk("R9 write while locked", v, 16'hFFFF);
        cmd_data(2'b00, 6'b01_0000, 16'h0000);
        read_word(6'd20, v);
        chk("R9 write-all while locked", v, 16'hFFFF);
    endtask

    task automatic t_write();
        logic [15:0] v;
        cmd(2'b00, 6'b11_0101);
        cmd_data(2'b01, 6'd3, 16'hA5C3);
        // R2: leading zero bits before the start bit are skipped
        sel_on();
        pulse(1'b0);
        pulse(1'b0);
        header(2'b01, 6'd63);
        send_word(16'h0001);
        sel_off();
        read_word(6'd3, v);
        chk("R4 R6 write word 3", v, 16'hA5C3);
        read_word(6'd63, v);
        chk("R2 R4 write word 63", v, 16'h0001);
    endtask

    task automatic t_erase();
        logic [15:0] v;
        cmd(2'b11, 6'd3);
        read_word(6'd3, v);
        chk("R5 erased word", v, 16'hFFFF);
        read_word(6'd63, v);
        chk("R5 neighbour kept", v, 16'h0001);
    endtask

    task automatic t_fill();
        logic [15:0] v;
        cmd_data(2'b00, 6'b01_1010, 16'h5A0F);
        read_word(6'd0, v);
        chk("R8 write-all word 0", v, 16'h5A0F);
        read_word(6'd40, v);
        chk("R8 write-all word 40", v, 16'h5A0F);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        cmd(2'b00, 6'b00_1010);
        cmd(2'b11, 6'd0);
        read_word(6'd0, v);
        chk("R6 R9 erase after lock", v, 16'h5A0F);
        cmd(2'b00, 6'b10_0000);
        read_word(6'd7, v);
        chk("R9 erase-all after lock", v, 16'h5A0F);
    endtask

    task automatic t_wipe();
        logic [15:0] v;
        cmd(2'b00, 6'b11_0000);
        cmd(2'b00, 6'b10_1111);
        read_word(6'd0, v);
        chk("R7 erase-all word 0", v, 16'hFFFF);
        read_word(6'd40, v);
        chk("R7 erase-all word 40", v, 16'hFFFF);
    endtask

    task automatic t_abort();
        logic [15:0] v;
        sel_on();
        header(2'b01, 6'd9);
        for (int i = 0; i < 8; i++) pulse(1'b0);
        @(negedge clk);
        cs = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 dout low while deselected", {15'd0, dout}, 16'd0);
        sel_off();
        read_word(6'd9, v);
        chk("R10 aborted write", v, 16'hFFFF);
        cmd_data(2'b01, 6'd9, 16'h0F0F);
        read_word(6'd9, v);
        chk("R10 write after abort", v, 16'h0F0F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_locked();
        t_write();
        t_erase();
        t_fill();
        t_lock();
        t_wipe();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule